// File: doc/BRIEF.md
# Page-Oriented Flash Array Model

This block is a synthesizable stand-in for a small NAND-style flash array. Flash controllers can run against it in simulation or on an FPGA prototype, with no flash device attached. The array is split into blocks and blocks into pages. Each page holds a main area followed by a spare area. The whole page is moved as one sequential byte stream that always starts at byte 0. No single byte can be addressed on its own.

Three commands arrive on a valid/ready port: page read, page program and block erase. A command names a block and a page. While an operation is in progress the block drives busy and refuses further commands. When the operation ends it raises a one-cycle done pulse together with held status flags.

The model follows the flash write rules. A program can only pull bits down, so the cell keeps the AND of its old value and the new byte. Only an erase returns a whole block, spare bytes included, to all ones. An optional strict mode flags any program byte that would need a bit to rise. A counter per block records how many erases that block has seen.

Top module: `flash_emu`

## Requirements
- R1: After reset, cmd_ready is 1, busy, done and fail are 0, every wear counter reads 0, and every byte of every page reads 8'hFF.
- R2: A read (cmd_op 2'd0) holds busy with out_valid low for T_READ cycles after the accepting edge. It then gives PAGE_BYTES bytes on consecutive cycles with out_valid high: main bytes 0..MAIN_BYTES-1 first, then the spare bytes.
- R3: A program (cmd_op 2'd1) holds in_ready high until PAGE_BYTES bytes have been taken with in_valid, byte 0 first. Each stored byte becomes the old byte AND the incoming byte.
- R4: Programming the same page again is allowed. A sequence whose zero bits only grow (for example a low nibble written 1110, then 1010, then 0010, then 0000) reaches each target value exactly.
- R5: An erase (cmd_op 2'd2) sets every main and spare byte of every page in the named block to 8'hFF. Pages in other blocks keep their contents.
- R6: busy is high from the accepting edge until the operation ends, and cmd_ready is low the whole time. After the last data byte a program stays busy for T_PROG cycles. An erase stays busy for T_ERASE cycles after acceptance.
- R7: A command is rejected in any of these cases: a block index of BLOCKS or more, a page index of PAGES or more on a read or program, or cmd_op 2'd3. The page field of an erase is ignored. A rejected command does not raise busy. done and fail are high in the cycle after acceptance, and the array is left unchanged.
- R8: When cmd_strict is 1 at acceptance, a program in which any byte has a 1 where the stored bit is 0 ends with strict_err set. The AND result is still stored. With cmd_strict at 0, strict_err stays 0.
- R9: Each erase adds one to the counter of that block only. The counter is read as wear_count for the block selected by wear_sel.
- R10: done is a single-cycle pulse at the end of each operation. fail and strict_err keep their values until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (not busy) |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 invalid |
| cmd_block | input | BA_W | Block index |
| cmd_page | input | PA_W | Page index within the block |
| cmd_strict | input | 1 | Flag program bytes that need a 0-to-1 change |
| in_valid | input | 1 | Program data byte valid |
| in_data | input | 8 | Program data byte |
| in_ready | output | 1 | Program data being collected |
| out_valid | output | 1 | Read data byte valid |
| out_data | output | 8 | Read data byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail | output | 1 | Last command was rejected |
| strict_err | output | 1 | Last program tried a 0-to-1 change in strict mode |
| wear_sel | input | BW | Block whose erase count is shown |
| wear_count | output | WEAR_W | Erase count of the selected block |

## Verification
The bench keeps its own image of the array. It reprograms a page with data that is not a superset of the stored zeros. A design that stored the new byte in place of the AND would return the wrong bytes on the next read. It walks one low nibble down through the 1110, 1010, 0010, 0000 ladder in strict mode, which catches both stray strict flags and lost bits. It then programs a neighbour page and a neighbour block, erases one block and reads all of them back. An erase that is too wide shows up as ones in a neighbour, and one that skips the spare area shows up as stale spare bytes. It also sends out-of-range and invalid commands, one of them an erase with an unused page number. The read latency and the program and erase busy windows are counted to the exact cycle, so a counter that is off by one is caught.

// File: rtl/flash_emu.sv
module flash_emu #(
  parameter int BLOCKS      = 4,
  parameter int PAGES       = 4,
  parameter int MAIN_BYTES  = 16,
  parameter int SPARE_BYTES = 4,
  parameter int T_READ      = 3,
  parameter int T_PROG      = 6,
  parameter int T_ERASE     = 10,
  parameter int WEAR_W      = 16,
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
  localparam int NPG        = BLOCKS * PAGES,
  localparam int TOTAL      = NPG * PAGE_BYTES,
  localparam int BA_W       = $clog2(BLOCKS + 1),
  localparam int PA_W       = $clog2(PAGES + 1),
  localparam int BW         = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int LIN_W      = (NPG > 1) ? $clog2(NPG) : 1,
  localparam int ADDR_W     = $clog2(TOTAL),
  localparam int IDX_W      = $clog2(PAGE_BYTES),
  localparam int LAT_W      = $clog2(T_ERASE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [BA_W-1:0]   cmd_block,
  input  logic [PA_W-1:0]   cmd_page,
  input  logic              cmd_strict,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              strict_err,
  input  logic [BW-1:0]     wear_sel,
  output logic [WEAR_W-1:0] wear_count
);

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_PROG  = 2'd1;
  localparam logic [1:0] OP_ERASE = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT, S_STREAM} state_t;

  state_t            state;
  logic [1:0]        op_q;
  logic [BW-1:0]     blk_q;
  logic [LIN_W-1:0]  lin_q;
  logic              strict_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LAT_W-1:0]  cnt_q;
  logic [NPG-1:0]    written;
  logic [WEAR_W-1:0] wear [BLOCKS];
  logic [7:0]        mem [TOTAL];

  logic              accept, in_range, last;
  logic [LIN_W-1:0]  cmd_lin;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        old_byte;

  assign busy      = state != S_IDLE;
  assign cmd_ready = !busy;
  assign in_ready  = state == S_LOAD;
  assign out_valid = state == S_STREAM;
  assign accept    = cmd_valid && cmd_ready;
  assign in_range  = (cmd_block < BA_W'(BLOCKS)) && (cmd_op != 2'd3) &&
                     (cmd_op == OP_ERASE || cmd_page < PA_W'(PAGES));
  assign cmd_lin   = LIN_W'(int'(cmd_block) * PAGES + int'(cmd_page));
  assign addr      = ADDR_W'(int'(lin_q) * PAGE_BYTES + int'(idx_q));
  assign old_byte  = written[lin_q] ? mem[addr] : 8'hFF;
  assign last      = idx_q == IDX_W'(PAGE_BYTES - 1);
  assign out_data  = out_valid ? old_byte : 8'h00;
  assign wear_count = wear[wear_sel];

  always_ff @(posedge clk) begin
    if (state == S_LOAD && in_valid)
      mem[addr] <= old_byte & in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_q       <= OP_READ;
      blk_q      <= '0;
      lin_q      <= '0;
      strict_q   <= 1'b0;
      idx_q      <= '0;
      cnt_q      <= '0;
      written    <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
      strict_err <= 1'b0;
      for (int b = 0; b < BLOCKS; b++) wear[b] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          fail       <= 1'b0;
          strict_err <= 1'b0;
          op_q       <= cmd_op;
          blk_q      <= BW'(cmd_block);
          lin_q      <= cmd_lin;
          strict_q   <= cmd_strict;
          idx_q      <= '0;
          if (!in_range) begin
            done <= 1'b1;
            fail <= 1'b1;
          end else if (cmd_op == OP_PROG) begin
            state <= S_LOAD;
          end else begin
            state <= S_WAIT;
            cnt_q <= (cmd_op == OP_READ) ? LAT_W'(T_READ - 1) : LAT_W'(T_ERASE - 1);
          end
        end
        S_LOAD: if (in_valid) begin
          if (strict_q && |(in_data & ~old_byte)) strict_err <= 1'b1;
          idx_q <= idx_q + IDX_W'(1);
          if (last) begin
            written[lin_q] <= 1'b1;
            idx_q <= '0;
            cnt_q <= LAT_W'(T_PROG - 1);
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - LAT_W'(1);
          end else if (op_q == OP_READ) begin
            state <= S_STREAM;
          end else begin
            if (op_q == OP_ERASE) begin
              for (int p = 0; p < PAGES; p++)
                written[LIN_W'(int'(blk_q) * PAGES + p)] <= 1'b0;
              wear[blk_q] <= wear[blk_q] + WEAR_W'(1);
            end
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        S_STREAM: begin
          idx_q <= idx_q + IDX_W'(1);
          if (last) begin
            idx_q <= '0;
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_emu_chk.sv
module flash_emu_chk #(
  parameter int BLOCKS = 4,
  parameter int PAGES  = 4,
  parameter int BA_W   = 3,
  parameter int PA_W   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [1:0]      cmd_op,
  input logic [BA_W-1:0] cmd_block,
  input logic [PA_W-1:0] cmd_page,
  input logic            in_ready,
  input logic            out_valid,
  input logic            busy,
  input logic            done,
  input logic            fail,
  input logic            strict_err
);

  logic take, bad;
  assign take = cmd_valid && cmd_ready;
  assign bad  = (int'(cmd_block) >= BLOCKS) || (cmd_op == 2'd3) ||
                (cmd_op != 2'd2 && int'(cmd_page) >= PAGES);

  // R6
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  // R6
  good_cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bad) |=> busy);

  // R7
  bad_cmd_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bad) |=> (done && fail && !busy));

  // R2
  stream_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (busy && !in_ready));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(fail));

  // R8
  serr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !in_ready) |=> $stable(strict_err));

endmodule

bind flash_emu flash_emu_chk #(
  .BLOCKS(BLOCKS), .PAGES(PAGES), .BA_W(BA_W), .PA_W(PA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_block(cmd_block), .cmd_page(cmd_page),
  .in_ready(in_ready), .out_valid(out_valid), .busy(busy), .done(done),
  .fail(fail), .strict_err(strict_err)
);

// File: tb/flash_emu_tb_top.sv
module flash_emu_tb_top;
  localparam int NB = 4, NP = 4, PB = 20, TR = 3, TP = 6, TE = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_strict = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [2:0] cmd_block = '0, cmd_page = '0;
  logic in_valid = 1'b0, in_ready, out_valid, busy, done, fail, strict_err;
  logic [7:0] in_data = '0, out_data;
  logic [1:0] wear_sel = '0;
  logic [15:0] wear_count;

  int checks = 0, errors = 0;
  logic [7:0] ref_mem [NB*NP*PB];
  int wear_exp [NB];

  always #5 clk = ~clk;

  flash_emu dut_i (.*);

  // entry: {op, block, page, seed, strict}; seed[8]=1 means constant byte seed[7:0]
  localparam int NV = 31;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0,3'd0,3'd0,9'h000,1'b0},  // R1 erased read
    {2'd0,3'd3,3'd3,9'h000,1'b0},  // R1
    {2'd1,3'd1,3'd2,9'h05A,1'b0},  // R3
    {2'd0,3'd1,3'd2,9'h000,1'b0},
    {2'd1,3'd1,3'd2,9'h033,1'b0},  // R3 AND, R8 strict off
    {2'd0,3'd1,3'd2,9'h000,1'b0},
    {2'd1,3'd2,3'd0,9'h1FE,1'b1},  // R4 ladder
    {2'd1,3'd2,3'd0,9'h1FA,1'b1},
    {2'd0,3'd2,3'd0,9'h000,1'b0},
    {2'd1,3'd2,3'd0,9'h1F2,1'b1},
    {2'd1,3'd2,3'd0,9'h1F0,1'b1},
    {2'd0,3'd2,3'd0,9'h000,1'b0},
    {2'd1,3'd2,3'd0,9'h1FF,1'b1},  // R8 strict error
    {2'd0,3'd2,3'd0,9'h000,1'b0},
    {2'd1,3'd2,3'd1,9'h011,1'b0},
    {2'd1,3'd3,3'd0,9'h077,1'b0},
    {2'd2,3'd2,3'd0,9'h000,1'b0},  // R5 erase
    {2'd0,3'd2,3'd0,9'h000,1'b0},
    {2'd0,3'd2,3'd1,9'h000,1'b0},
    {2'd0,3'd1,3'd2,9'h000,1'b0},  // R5 isolation
    {2'd0,3'd3,3'd0,9'h000,1'b0},
    {2'd0,3'd4,3'd0,9'h000,1'b0},  // R7 bad block
    {2'd1,3'd1,3'd4,9'h0AA,1'b0},  // R7 bad page
    {2'd3,3'd0,3'd0,9'h000,1'b0},  // R7 bad op
    {2'd2,3'd5,3'd0,9'h000,1'b0},  // R7 bad erase block
    {2'd2,3'd2,3'd7,9'h000,1'b0},  // R7 erase page ignored
    {2'd2,3'd0,3'd0,9'h000,1'b0},
    {2'd1,3'd2,3'd0,9'h02C,1'b0},
    {2'd0,3'd2,3'd0,9'h000,1'b0},
    {2'd0,3'd0,3'd0,9'h000,1'b0},
    {2'd0,3'd1,3'd2,9'h000,1'b0}   // R7 no change from rejected program
  };

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(logic [8:0] s, int i);
    return s[8] ? s[7:0] : (s[7:0] ^ 8'(i * 37));
  endfunction

  task automatic run_op(logic [1:0] op, int b, int p, logic [8:0] seed, bit st);
    bit bad;
    int base, n;
    bit exp_s;
    logic [7:0] d;
    bad = (b >= NB) || (op == 2'd3) || (op != 2'd2 && p >= NP);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_block = 3'(b); cmd_page = 3'(p); cmd_strict = st;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (bad) begin
      chk(done && fail && !busy, "R7 rejected command", {done, fail, busy}, 3'b110);
      return;
    end
    base = (b * NP + p) * PB;
    n = 0;
    case (op)
      2'd1: begin
        exp_s = 1'b0;
        for (int i = 0; i < PB; i++) begin
          d = pat(seed, i);
          chk(in_ready, "R3 in_ready during load", in_ready, 1);
          exp_s |= |(d & ~ref_mem[base + i]);
          ref_mem[base + i] = ref_mem[base + i] & d;
          in_valid = 1'b1; in_data = d;
          @(negedge clk);
        end
        in_valid = 1'b0;
        while (busy && n < 1000) begin
          chk(!cmd_ready, "R6 ready low while busy", cmd_ready, 0);
          n++; @(negedge clk);
        end
        chk(n == TP, "R6 program busy cycles", n, TP);
        chk(done && !fail, "R10 program done", {done, fail}, 2);
        chk(strict_err == (st && exp_s), "R8 strict flag", strict_err, int'(st && exp_s));
      end
      2'd2: begin
        while (busy && n < 1000) begin
          chk(!cmd_ready, "R6 ready low while busy", cmd_ready, 0);
          n++; @(negedge clk);
        end
        chk(n == TE, "R6 erase busy cycles", n, TE);
        chk(done && !fail, "R10 erase done", {done, fail}, 2);
        for (int i = 0; i < NP * PB; i++) ref_mem[b * NP * PB + i] = 8'hFF;
        wear_exp[b]++;
      end
      default: begin
        while (busy && !out_valid && n < 1000) begin n++; @(negedge clk); end
        chk(n == TR, "R2 read latency", n, TR);
        for (int i = 0; i < PB; i++) begin
          chk(out_valid && out_data == ref_mem[base + i], "R2 R5 read byte",
              int'(out_data), int'(ref_mem[base + i]));
          @(negedge clk);
        end
        chk(done && !busy, "R10 read done", {done, busy}, 2);
      end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB*NP*PB; i++) ref_mem[i] = 8'hFF;
    for (int b = 0; b < NB; b++) wear_exp[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !busy && !done && !fail && !out_valid, "R1 reset outputs",
        {cmd_ready, busy, done, fail, out_valid}, 5'b10000);
    for (int b = 0; b < NB; b++) begin
      wear_sel = 2'(b); #1;
      chk(wear_count == 0, "R1 wear after reset", int'(wear_count), 0);
    end

    for (int v = 0; v < NV; v++)
      run_op(VEC[v][17:16], int'(VEC[v][15:13]), int'(VEC[v][12:10]), VEC[v][9:1], VEC[v][0]);

    // R10 status held after done pulse
    run_op(2'd0, 6, 0, 9'h000, 1'b0);
    @(negedge clk);
    chk(!done, "R10 done single pulse", done, 0);
    repeat (3) @(negedge clk);
    chk(fail, "R10 fail held", fail, 1);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_block = 3'd0; cmd_page = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!fail && busy, "R10 fail cleared on new command", {fail, busy}, 1);
    while (busy) @(negedge clk);

    // R9 wear counters
    for (int b = 0; b < NB; b++) begin
      wear_sel = 2'(b); #1;
      chk(int'(wear_count) == wear_exp[b], "R9 wear count", int'(wear_count), wear_exp[b]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule